// File: doc/BRIEF.md
# Pipeline Exception Commit Controller

This controller gives a five-stage in-order pipeline precise exceptions. Three stage registers sit beside the datapath's own pipeline registers: fetch-to-decode, decode-to-execute and execute-to-memory. Each one carries a valid bit, the instruction's address and a 3-bit cause tag. An instruction is fetched with no cause. Decode may add a trap cause. The memory stage may add a load or store fault. The tag only travels with the instruction until that instruction reaches the memory stage, which is the single place where exceptions take effect.

When the memory-stage instruction has a cause, the controller does four things. It blocks every memory and register side effect of that instruction. It raises flush strobes for all three stage registers. It loads the program counter with the faulting address plus the instruction size. It reports the cause, and it pulses a breakpoint output when the cause is a break. Once an exception is known in decode or execute, the instructions behind it are squashed at once. The redirect is then taken when the excepting instruction itself commits.

The surrounding datapath issues raw memory and register-write requests for the instruction in the memory stage. It uses the gated enables from this block in their place. It also clears its own pipeline registers on the matching flush strobes.

Top module: `exc_commit_ctrl`

## Requirements
- R1: While reset is held, and after it, all three stage registers are empty (no valid instruction, cause 0, address 0). No enable, flush, redirect, break or cause output is active, whatever the requests are. The cause output reads 0 in every cycle with no commit.
- R2: An instruction fetched in cycle n with if_valid_i high, and never squashed, occupies the memory stage in cycle n+3. With no cause present there, each enable equals its request.
- R3: Cause codes are 0 none, 1 syscall, 2 break, 3 load fault, 4 store fault. In the cycle an instruction sits in decode, the trap flag gives it id_trap_cause_i only if the instruction is valid and carries no cause yet. A trap flag in a cycle with no valid instruction in decode is ignored.
- R4: At the memory stage, a carried cause wins over a fault input. A load fault (cause 3) wins over a store fault (cause 4) when both are high. Faults are ignored for an empty memory stage.
- R5: In a cycle where the memory stage commits an exception, the memory read, memory write, cache-sync and register-write enables are all 0.
- R6: A commit raises all three flush strobes. Otherwise, an exception in execute raises the flushes of fetch-to-decode and decode-to-execute. Otherwise, an exception in decode raises only the fetch-to-decode flush. A flushed register holds an empty slot on the next cycle.
- R7: On a commit, pc_load_o is high and pc_target_o equals the faulting address plus 4, and exc_cause_o gives the committed cause.
- R8: brk_hit_o is high exactly in a cycle that commits cause 2.
- R9: A commit's redirect wins over a taken branch in the same cycle. Any flush makes all stage registers advance despite hold_i. Without a commit, a taken branch drives pc_load_o with br_target_i.
- R10: With hold_i high and no flush, the stage registers keep their contents.
- R11: An empty memory stage produces no enable and no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| if_valid_i | input | 1 | A real instruction is fetched this cycle |
| if_addr_i | input | AW | Address of the fetched instruction |
| id_trap_i | input | 1 | Decode marks its instruction as exception-raising |
| id_trap_cause_i | input | 3 | Cause encoded by the decoding instruction |
| hold_i | input | 1 | Stall request from hazard logic |
| br_take_i | input | 1 | Taken branch or jump this cycle |
| br_target_i | input | AW | Branch or jump destination |
| mem_rd_req_i | input | 1 | Memory-stage read request |
| mem_wr_req_i | input | 1 | Memory-stage write request |
| mem_sync_req_i | input | 1 | Memory-stage cache-sync request |
| reg_wr_req_i | input | 1 | Register-write request of the memory-stage instruction |
| mem_ld_fault_i | input | 1 | Address check reports a load fault |
| mem_st_fault_i | input | 1 | Address check reports a store fault |
| flush_fd_o | output | 1 | Clear the fetch-to-decode register |
| flush_de_o | output | 1 | Clear the decode-to-execute register |
| flush_em_o | output | 1 | Clear the execute-to-memory register |
| pc_load_o | output | 1 | Load the program counter |
| pc_target_o | output | AW | New program counter value |
| exc_commit_o | output | 1 | An exception commits this cycle |
| exc_cause_o | output | 3 | Committed cause, 0 when none |
| brk_hit_o | output | 1 | Breakpoint reached |
| mem_rd_en_o | output | 1 | Gated memory read |
| mem_wr_en_o | output | 1 | Gated memory write |
| mem_sync_en_o | output | 1 | Gated cache sync |
| reg_wr_en_o | output | 1 | Gated register write |

## Verification
The checker watches several local rules on every cycle. A commit never lets a memory access or register write through, and it always drives a redirect. Flushes nest from older stages to younger ones. A break pulse only appears together with a cause-2 commit. The cycle after a commit shows an empty memory stage. An exception that leaves execute on a flush commits in the next cycle.

Other behaviours need whole instruction sequences, so only the bench scenarios can show them. These are the redirect target equal to the faulting address plus 4, and the earliest cause winning over later faults. They also include the instructions behind a fault never writing a register while the refetched ones write again, a trap on an empty decode slot being ignored, and hold delaying arrival at the memory stage by exactly one cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;

   localparam int unsigned CAUSE_W = 3;

   // Encoding is visible at the ports; values are fixed.
   typedef enum logic [CAUSE_W-1:0] {
      CAUSE_NONE     = 3'd0,
      CAUSE_SYSCALL  = 3'd1,
      CAUSE_BREAK    = 3'd2,
      CAUSE_LD_FAULT = 3'd3,
      CAUSE_ST_FAULT = 3'd4
   } cause_e;

endpackage

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
   import exc_pkg::*;
#(
   parameter int unsigned AW        = 32,
   parameter bit          ASYNC_RST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_i,
   input  logic          load_i,
   input  logic          d_valid_i,
   input  cause_e        d_cause_i,
   input  logic [AW-1:0] d_addr_i,
   output logic          q_valid_o,
   output cause_e        q_cause_o,
   output logic [AW-1:0] q_addr_o
);

   logic          nx_valid;
   cause_e        nx_cause;
   logic [AW-1:0] nx_addr;

   // Clear wins over load; no load means hold.
   always_comb begin
      nx_valid = q_valid_o;
      nx_cause = q_cause_o;
      nx_addr  = q_addr_o;
      if (clear_i) begin
         nx_valid = 1'b0;
         nx_cause = CAUSE_NONE;
         nx_addr  = '0;
      end else if (load_i) begin
         nx_valid = d_valid_i;
         nx_cause = d_cause_i;
         nx_addr  = d_addr_i;
      end
   end

   generate
      if (ASYNC_RST) begin : g_arst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_valid_o <= 1'b0;
               q_cause_o <= CAUSE_NONE;
               q_addr_o  <= '0;
            end else begin
               q_valid_o <= nx_valid;
               q_cause_o <= nx_cause;
               q_addr_o  <= nx_addr;
            end
         end
      end else begin : g_srst
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q_valid_o <= 1'b0;
               q_cause_o <= CAUSE_NONE;
               q_addr_o  <= '0;
            end else begin
               q_valid_o <= nx_valid;
               q_cause_o <= nx_cause;
               q_addr_o  <= nx_addr;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/exc_decode_merge.sv
module exc_decode_merge
   import exc_pkg::*;
(
   input  logic               valid_i,
   input  cause_e             carried_i,
   input  logic               trap_i,
   input  logic [CAUSE_W-1:0] trap_cause_i,
   output cause_e             cause_o,
   output logic               raise_o
);

   // Earliest cause wins; empty slots never raise.
   always_comb begin
      cause_o = CAUSE_NONE;
      if (valid_i) begin
         if (carried_i != CAUSE_NONE) begin
            cause_o = carried_i;
         end else if (trap_i) begin
            cause_o = cause_e'(trap_cause_i);
         end
      end
   end

   assign raise_o = (cause_o != CAUSE_NONE);

endmodule

// File: rtl/exc_mem_commit.sv
module exc_mem_commit
   import exc_pkg::*;
#(
   parameter int unsigned AW             = 32,
   parameter int unsigned INSN_BYTES     = 4,
   parameter bit          LD_FAULT_FIRST = 1'b1
) (
   input  logic          valid_i,
   input  cause_e        carried_i,
   input  logic [AW-1:0] addr_i,
   input  logic          rd_req_i,
   input  logic          wr_req_i,
   input  logic          sync_req_i,
   input  logic          rw_req_i,
   input  logic          ld_fault_i,
   input  logic          st_fault_i,
   output logic          rd_en_o,
   output logic          wr_en_o,
   output logic          sync_en_o,
   output logic          rw_en_o,
   output logic          commit_o,
   output cause_e        cause_o,
   output logic [AW-1:0] target_o,
   output logic          brk_o
);

   localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

   cause_e fault_cause;
   logic   clean;

   generate
      if (LD_FAULT_FIRST) begin : g_ld_first
         always_comb begin
            if (ld_fault_i)      fault_cause = CAUSE_LD_FAULT;
            else if (st_fault_i) fault_cause = CAUSE_ST_FAULT;
            else                 fault_cause = CAUSE_NONE;
         end
      end else begin : g_st_first
         always_comb begin
            if (st_fault_i)      fault_cause = CAUSE_ST_FAULT;
            else if (ld_fault_i) fault_cause = CAUSE_LD_FAULT;
            else                 fault_cause = CAUSE_NONE;
         end
      end
   endgenerate

   // Carried cause ranks above a fault raised here.
   always_comb begin
      cause_o = CAUSE_NONE;
      if (valid_i) begin
         cause_o = (carried_i != CAUSE_NONE) ? carried_i : fault_cause;
      end
   end

   assign commit_o  = (cause_o != CAUSE_NONE);
   assign clean     = valid_i & ~commit_o;
   assign rd_en_o   = rd_req_i   & clean;
   assign wr_en_o   = wr_req_i   & clean;
   assign sync_en_o = sync_req_i & clean;
   assign rw_en_o   = rw_req_i   & clean;
   assign target_o  = addr_i + STEP;
   assign brk_o     = (cause_o == CAUSE_BREAK);

endmodule

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl
   import exc_pkg::*;
#(
   parameter int unsigned AW             = 32,
   parameter int unsigned INSN_BYTES     = 4,
   parameter bit          ASYNC_RST      = 1'b1,
   parameter bit          LD_FAULT_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          if_valid_i,
   input  logic [AW-1:0] if_addr_i,
   input  logic          id_trap_i,
   input  logic [2:0]    id_trap_cause_i,
   input  logic          hold_i,
   input  logic          br_take_i,
   input  logic [AW-1:0] br_target_i,
   input  logic          mem_rd_req_i,
   input  logic          mem_wr_req_i,
   input  logic          mem_sync_req_i,
   input  logic          reg_wr_req_i,
   input  logic          mem_ld_fault_i,
   input  logic          mem_st_fault_i,
   output logic          flush_fd_o,
   output logic          flush_de_o,
   output logic          flush_em_o,
   output logic          pc_load_o,
   output logic [AW-1:0] pc_target_o,
   output logic          exc_commit_o,
   output logic [2:0]    exc_cause_o,
   output logic          brk_hit_o,
   output logic          mem_rd_en_o,
   output logic          mem_wr_en_o,
   output logic          mem_sync_en_o,
   output logic          reg_wr_en_o
);

   generate
      if (AW < 8) begin : g_bad_aw
         $error("exc_commit_ctrl: AW must be at least 8");
      end
      if (INSN_BYTES == 0 || (INSN_BYTES & (INSN_BYTES - 1)) != 0) begin : g_bad_step
         $error("exc_commit_ctrl: INSN_BYTES must be a power of two");
      end
   endgenerate

   logic          fd_valid, de_valid, em_valid;
   cause_e        fd_cause, de_cause, em_cause;
   logic [AW-1:0] fd_addr, de_addr, em_addr;

   cause_e        dec_cause;
   logic          dec_raise;
   logic          ex_raise;
   logic          commit;
   cause_e        commit_cause;
   logic [AW-1:0] redirect_pc;
   logic          advance;

   // Older stage exception squashes every younger slot.
   assign ex_raise   = de_valid && (de_cause != CAUSE_NONE);
   assign flush_em_o = commit;
   assign flush_de_o = commit | ex_raise;
   assign flush_fd_o = commit | ex_raise | dec_raise;
   assign advance    = ~hold_i | flush_fd_o;

   exc_stage_reg #(.AW(AW), .ASYNC_RST(ASYNC_RST)) u_fd (
      .clk(clk), .rst_n(rst_n), .clear_i(flush_fd_o), .load_i(advance),
      .d_valid_i(if_valid_i), .d_cause_i(CAUSE_NONE), .d_addr_i(if_addr_i),
      .q_valid_o(fd_valid), .q_cause_o(fd_cause), .q_addr_o(fd_addr)
   );

   exc_decode_merge u_dec (
      .valid_i(fd_valid), .carried_i(fd_cause), .trap_i(id_trap_i),
      .trap_cause_i(id_trap_cause_i), .cause_o(dec_cause), .raise_o(dec_raise)
   );

   exc_stage_reg #(.AW(AW), .ASYNC_RST(ASYNC_RST)) u_de (
      .clk(clk), .rst_n(rst_n), .clear_i(flush_de_o), .load_i(advance),
      .d_valid_i(fd_valid), .d_cause_i(dec_cause), .d_addr_i(fd_addr),
      .q_valid_o(de_valid), .q_cause_o(de_cause), .q_addr_o(de_addr)
   );

   // Execute forwards the tag untouched.
   exc_stage_reg #(.AW(AW), .ASYNC_RST(ASYNC_RST)) u_em (
      .clk(clk), .rst_n(rst_n), .clear_i(flush_em_o), .load_i(advance),
      .d_valid_i(de_valid), .d_cause_i(de_cause), .d_addr_i(de_addr),
      .q_valid_o(em_valid), .q_cause_o(em_cause), .q_addr_o(em_addr)
   );

   exc_mem_commit #(
      .AW(AW), .INSN_BYTES(INSN_BYTES), .LD_FAULT_FIRST(LD_FAULT_FIRST)
   ) u_mem (
      .valid_i(em_valid), .carried_i(em_cause), .addr_i(em_addr),
      .rd_req_i(mem_rd_req_i), .wr_req_i(mem_wr_req_i),
      .sync_req_i(mem_sync_req_i), .rw_req_i(reg_wr_req_i),
      .ld_fault_i(mem_ld_fault_i), .st_fault_i(mem_st_fault_i),
      .rd_en_o(mem_rd_en_o), .wr_en_o(mem_wr_en_o),
      .sync_en_o(mem_sync_en_o), .rw_en_o(reg_wr_en_o),
      .commit_o(commit), .cause_o(commit_cause), .target_o(redirect_pc),
      .brk_o(brk_hit_o)
   );

   // Exception redirect outranks any branch.
   assign pc_load_o    = commit | br_take_i;
   assign pc_target_o  = commit ? redirect_pc : br_target_i;
   assign exc_commit_o = commit;
   assign exc_cause_o  = commit_cause;

endmodule

// File: rtl/exc_commit_chk.sv
module exc_commit_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       flush_fd_o,
   input logic       flush_de_o,
   input logic       flush_em_o,
   input logic       pc_load_o,
   input logic       exc_commit_o,
   input logic [2:0] exc_cause_o,
   input logic       brk_hit_o,
   input logic       mem_rd_en_o,
   input logic       mem_wr_en_o,
   input logic       mem_sync_en_o,
   input logic       reg_wr_en_o
);

   // R5
   side_effect_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_commit_o |-> !mem_rd_en_o && !mem_wr_en_o && !mem_sync_en_o && !reg_wr_en_o);

   // R6
   flush_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_em_o |-> flush_de_o) and (flush_de_o |-> flush_fd_o));

   // R6
   empty_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_commit_o |=> !exc_commit_o && !reg_wr_en_o && !mem_wr_en_o);

   // R7
   redirect_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_commit_o |-> pc_load_o);

   // R7
   exec_exc_commits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_de_o && !exc_commit_o |=> exc_commit_o);

   // R8
   brk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_hit_o |-> exc_commit_o && exc_cause_o == 3'd2);

   // R1
   quiet_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_commit_o |-> exc_cause_o == 3'd0);

endmodule

bind exc_commit_ctrl exc_commit_chk u_chk (
   .clk(clk), .rst_n(rst_n),
   .flush_fd_o(flush_fd_o), .flush_de_o(flush_de_o), .flush_em_o(flush_em_o),
   .pc_load_o(pc_load_o), .exc_commit_o(exc_commit_o), .exc_cause_o(exc_cause_o),
   .brk_hit_o(brk_hit_o), .mem_rd_en_o(mem_rd_en_o), .mem_wr_en_o(mem_wr_en_o),
   .mem_sync_en_o(mem_sync_en_o), .reg_wr_en_o(reg_wr_en_o)
);

// File: tb/exc_commit_ctrl_tb.sv
module exc_commit_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] BRT = 32'h0000_9000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ifv = 1'b0;
   logic [31:0] ifa = '0;
   logic        trp = 1'b0;
   logic [2:0]  tcs = '0;
   logic        hld = 1'b0;
   logic        brk_take = 1'b0;
   logic        rd = 1'b0, wr = 1'b0, sy = 1'b0, rw = 1'b0;
   logic        ldf = 1'b0, stf = 1'b0;

   logic        f_fd, f_de, f_em, pcl, cmt, bhit;
   logic [31:0] tgt;
   logic [2:0]  cause;
   logic        rde, wre, sye, rwe;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   exc_commit_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .if_valid_i(ifv), .if_addr_i(ifa),
      .id_trap_i(trp), .id_trap_cause_i(tcs), .hold_i(hld),
      .br_take_i(brk_take), .br_target_i(BRT),
      .mem_rd_req_i(rd), .mem_wr_req_i(wr), .mem_sync_req_i(sy),
      .reg_wr_req_i(rw), .mem_ld_fault_i(ldf), .mem_st_fault_i(stf),
      .flush_fd_o(f_fd), .flush_de_o(f_de), .flush_em_o(f_em),
      .pc_load_o(pcl), .pc_target_o(tgt), .exc_commit_o(cmt),
      .exc_cause_o(cause), .brk_hit_o(bhit),
      .mem_rd_en_o(rde), .mem_wr_en_o(wre), .mem_sync_en_o(sye),
      .reg_wr_en_o(rwe)
   );

   typedef struct {
      logic        pcl;
      logic [31:0] tgt;
      logic [2:0]  cause;
      logic        brk;
      logic [3:0]  en;   // {rd, wr, sync, regwrite}
      logic [2:0]  fl;   // {em, de, fd}
      string       tag;
   } exp_t;

   exp_t sb[$];

   task automatic check(input bit ok, input string tag, input string act, input string exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%s expected=%s", tag, act, exp);
      end
   endtask

   // Driver: applies one cycle of stimulus and queues what must appear.
   task automatic step(input logic v, input logic [31:0] a, input logic t,
                       input logic [2:0] tc, input logic h, input logic b,
                       input logic [3:0] req, input logic [1:0] flt,
                       input logic epcl, input logic [31:0] etgt,
                       input logic [2:0] ecause, input logic ebrk,
                       input logic [3:0] een, input logic [2:0] efl,
                       input string tag);
      exp_t e;
      @(negedge clk);
      ifv = v; ifa = a; trp = t; tcs = tc; hld = h; brk_take = b;
      {rd, wr, sy, rw} = req;
      {ldf, stf} = flt;
      e.pcl = epcl; e.tgt = etgt; e.cause = ecause; e.brk = ebrk;
      e.en = een; e.fl = efl; e.tag = tag;
      sb.push_back(e);
   endtask

   // Monitor: compares one queued item per cycle, away from the clock edge.
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (sb.size() > 0) begin
            exp_t e;
            logic [3:0] aen;
            logic [2:0] afl;
            bit ok;
            e = sb.pop_front();
            aen = {rde, wre, sye, rwe};
            afl = {f_em, f_de, f_fd};
            ok = (pcl == e.pcl) && (!e.pcl || tgt == e.tgt) && (cause == e.cause)
                 && (bhit == e.brk) && (aen == e.en) && (afl == e.fl);
            check(ok, e.tag,
                  $sformatf("pcl=%0b tgt=%h cause=%0d brk=%0b en=%b fl=%b", pcl, tgt, cause, bhit, aen, afl),
                  $sformatf("pcl=%0b tgt=%h cause=%0d brk=%0b en=%b fl=%b", e.pcl, e.tgt, e.cause, e.brk, e.en, e.fl));
         end
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      ifv = 0; trp = 0; hld = 0; brk_take = 0; ldf = 0; stf = 0;
      {rd, wr, sy, rw} = 4'b1111;
      #2;
      // R1: nothing active under reset even with all requests high
      check({rde, wre, sye, rwe, f_fd, f_de, f_em, pcl, cmt, bhit} == '0 && cause == 3'd0,
            "R1 reset quiet", $sformatf("%b", {rde, wre, sye, rwe, f_fd, f_de, f_em, pcl, cmt, bhit}), "0");
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // S1 - R2 R11: plain flow, enables follow requests three cycles after fetch
      do_reset();
      step(1, 32'h1000, 0, 0, 0, 0, 4'b0101, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b000, "R11 empty mem c0");
      step(1, 32'h1004, 0, 0, 0, 0, 4'b0101, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b000, "R11 empty mem c1");
      step(1, 32'h1008, 0, 0, 0, 0, 4'b0101, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b000, "R11 empty mem c2");
      step(1, 32'h100C, 0, 0, 0, 0, 4'b0101, 2'b00, 0, 0, 0, 0, 4'b0101, 3'b000, "R2 store passes");
      step(1, 32'h1010, 0, 0, 0, 0, 4'b0101, 2'b00, 0, 0, 0, 0, 4'b0101, 3'b000, "R2 store passes 2");
      step(1, 32'h1014, 0, 0, 0, 0, 4'b1001, 2'b00, 0, 0, 0, 0, 4'b1001, 3'b000, "R2 load passes");
      step(1, 32'h1018, 0, 0, 0, 0, 4'b0011, 2'b00, 0, 0, 0, 0, 4'b0011, 3'b000, "R2 sync passes");

      // S2 - R3 R5 R6 R7: syscall raised in decode, younger work squashed
      do_reset();
      step(1, 32'h2000, 0, 0, 0, 0, 4'b0111, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b000, "R2 fetch");
      step(1, 32'h2004, 1, 1, 0, 0, 4'b0111, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b001, "R6 decode trap flush");
      step(1, 32'h2008, 0, 0, 0, 0, 4'b0111, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b011, "R6 exec exc flush");
      step(1, 32'h200C, 0, 0, 0, 0, 4'b0111, 2'b00, 1, 32'h2004, 1, 0, 4'b0000, 3'b111, "R5 R7 syscall commit");
      step(1, 32'h2004, 0, 0, 0, 0, 4'b0111, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b000, "R6 younger no write c4");
      step(1, 32'h2008, 0, 0, 0, 0, 4'b0111, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b000, "R6 younger no write c5");
      step(1, 32'h200C, 0, 0, 0, 0, 4'b0111, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b000, "R6 younger no write c6");
      step(1, 32'h2010, 0, 0, 0, 0, 4'b0111, 2'b00, 0, 0, 0, 0, 4'b0111, 3'b000, "R7 refetch writes");

      // S3 - R8 R9: break with hold and branch competing
      do_reset();
      step(1, 32'h3000, 0, 0, 0, 0, 4'b0001, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b000, "R2 fetch");
      step(1, 32'h3004, 1, 2, 0, 0, 4'b0001, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b001, "R3 break trap");
      step(1, 32'h3008, 0, 0, 1, 0, 4'b0001, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b011, "R9 flush beats hold");
      step(1, 32'h300C, 0, 0, 0, 1, 4'b0001, 2'b00, 1, 32'h3004, 2, 1, 4'b0000, 3'b111, "R8 R9 break beats branch");
      step(1, 32'h3004, 0, 0, 0, 1, 4'b0001, 2'b00, 1, BRT, 0, 0, 4'b0000, 3'b000, "R9 plain branch");

      // S4 - R4 R5: store fault, then load fault on the refetched instruction
      do_reset();
      step(1, 32'h4000, 0, 0, 0, 0, 4'b0101, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b000, "R11 c0");
      step(1, 32'h4004, 0, 0, 0, 0, 4'b0101, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b000, "R11 c1");
      step(1, 32'h4008, 0, 0, 0, 0, 4'b0101, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b000, "R11 c2");
      step(1, 32'h400C, 0, 0, 0, 0, 4'b0101, 2'b01, 1, 32'h4004, 4, 0, 4'b0000, 3'b111, "R4 R5 store fault no store");
      step(1, 32'h4004, 0, 0, 0, 0, 4'b0101, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b000, "R6 squashed c4");
      step(1, 32'h4008, 0, 0, 0, 0, 4'b0101, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b000, "R6 squashed c5");
      step(1, 32'h400C, 0, 0, 0, 0, 4'b0101, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b000, "R6 squashed c6");
      step(1, 32'h4010, 0, 0, 0, 0, 4'b1001, 2'b10, 1, 32'h4008, 3, 0, 4'b0000, 3'b111, "R4 R5 load fault no read");

      // S5 - R3 R4: carried syscall beats faults; load beats store
      do_reset();
      step(1, 32'h5000, 0, 0, 0, 0, 4'b1001, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b000, "R2 fetch");
      step(1, 32'h5004, 1, 1, 0, 0, 4'b1001, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b001, "R3 syscall trap");
      step(1, 32'h5008, 1, 2, 0, 0, 4'b1001, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b011, "R3 trap on squashed slot");
      step(1, 32'h500C, 0, 0, 0, 0, 4'b1001, 2'b11, 1, 32'h5004, 1, 0, 4'b0000, 3'b111, "R4 earliest cause wins");
      step(1, 32'h5004, 0, 0, 0, 0, 4'b1001, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b000, "R11 c4");
      step(1, 32'h5008, 0, 0, 0, 0, 4'b1001, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b000, "R11 c5");
      step(1, 32'h500C, 0, 0, 0, 0, 4'b1001, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b000, "R11 c6");
      step(1, 32'h5010, 0, 0, 0, 0, 4'b1001, 2'b11, 1, 32'h5008, 3, 0, 4'b0000, 3'b111, "R4 load over store");

      // S6 - R3 R11: trap on an empty decode slot is ignored, faults on empty memory ignored
      do_reset();
      step(0, 32'h0, 0, 0, 0, 0, 4'b1111, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b000, "R11 idle c0");
      step(0, 32'h0, 1, 2, 0, 0, 4'b1111, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b000, "R3 trap on bubble ignored");
      step(0, 32'h0, 0, 0, 0, 0, 4'b1111, 2'b11, 0, 0, 0, 0, 4'b0000, 3'b000, "R4 fault on empty ignored");
      step(0, 32'h0, 0, 0, 0, 0, 4'b1111, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b000, "R3 no commit from bubble");

      // S7 - R10: one hold cycle delays arrival at memory by one cycle
      do_reset();
      step(1, 32'h6000, 0, 0, 0, 0, 4'b0001, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b000, "R2 fetch");
      step(1, 32'h6004, 0, 0, 1, 0, 4'b0001, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b000, "R10 hold");
      step(1, 32'h6004, 0, 0, 0, 0, 4'b0001, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b000, "R10 after hold");
      step(1, 32'h6008, 0, 0, 0, 0, 4'b0001, 2'b00, 0, 0, 0, 0, 4'b0000, 3'b000, "R10 not yet in mem");
      step(1, 32'h600C, 0, 0, 0, 0, 4'b0001, 2'b00, 0, 0, 0, 0, 4'b0001, 3'b000, "R10 arrives late");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule